// File: doc/BRIEF.md
# Binary64 to Signed 32-bit Integer Converter

This block takes one IEEE-754 double-precision value and produces the signed 32-bit integer nearest to it under a selectable rounding direction. It is meant to sit inside a vector datapath as one lane of a packed conversion. Lane packing, exception masking and sticky status bits live outside it.

Each conversion yields a 32-bit result and two per-operation flags. The invalid flag marks inputs whose rounded value has no 32-bit signed representation. The inexact flag marks results that differ from the input. Unrepresentable inputs, which include every NaN and both infinities, return the fixed indefinite pattern 0x80000000. Subnormal inputs go through the normal path as very small magnitudes. The result and both flags are registered once, so each input pair is answered on the next rising clock edge.

Top module: `f2i_cvt`

## Requirements
- R1: The outputs are registered. An input applied before a rising edge of clk_i appears on res_o, invalid_o and inexact_o after that edge and not before it. While rst_ni is low all three outputs are zero.
- R2: An input whose value is an integer in [-2^31, 2^31-1] converts to that integer, in two's complement, with both flags low, under every rounding mode.
- R3: Whenever invalid_o is high, res_o equals 0x80000000.
- R4: rmode_i = 2'b00 rounds to the nearest integer, and a value exactly halfway between two integers goes to the even one (2.5 gives 2, 3.5 gives 4, -2.5 gives -2).
- R5: rmode_i = 2'b01 rounds toward minus infinity, 2'b10 rounds toward plus infinity, and 2'b11 rounds toward zero (-1.75 gives -2, -1 and -1 respectively).
- R6: Any input with an all-ones exponent field (bits 62:52), whether a quiet NaN, a signalling NaN or an infinity, raises invalid_o.
- R7: The range check applies to the rounded value. A value that rounds to exactly -2^31 is valid. A value that rounds to 2^31 or more, or to less than -2^31, is invalid. This includes 2147483647.5 under nearest-even rounding.
- R8: inexact_o is high exactly when the rounded result differs from the input and the conversion is valid. inexact_o and invalid_o are never high together.
- R9: Both zeros give 0 with no flags. A nonzero magnitude below 1, including subnormals, gives 0, +1 or -1 according to the rounding direction, and sets inexact_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 64 | Binary64 operand |
| rmode_i | input | 2 | Rounding direction: 00 nearest-even, 01 down, 10 up, 11 toward zero |
| res_o | output | 32 | Signed integer result |
| invalid_o | output | 1 | Rounded value not representable, or the input was NaN or infinity |
| inexact_o | output | 1 | Result differs from the input on a valid conversion |

## Verification
The rounding increment and the range check can act on the same operand in one cycle. A carry from rounding up can push a magnitude of 2^31-1 past the limit, and a negative value just below -2^31 can round back onto -2^31. The bench provokes both cases with operands at ±2^31 and halfway values near ±2^31 under each rounding mode. A real-valued reference model decides whether the invalid flag must win over inexact. Random halfway and in-range operands then exercise the same interaction across many magnitudes.

// File: rtl/f2i_pkg.sv
`timescale 1ns/1ps
package f2i_pkg;
  localparam int EXP_W   = 11;
  localparam int MAN_W   = 52;
  localparam int INT_W   = 32;
  localparam int FP_W    = EXP_W + MAN_W + 1;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int SIG_W   = MAN_W + 1;
  localparam int SH_MAX  = SIG_W + 1;
  localparam int SH_W    = $clog2(SH_MAX + 1);
  localparam int ALN_W   = SIG_W + SH_MAX;
  localparam int MAG_W   = INT_W + 1;
  localparam logic [INT_W-1:0] INDEF = {1'b1, {(INT_W-1){1'b0}}};

  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;
endpackage

// File: rtl/f2i_unpack.sv
`timescale 1ns/1ps
module f2i_unpack
  import f2i_pkg::*;
(
  input  logic [FP_W-1:0]  op_i,
  output logic             sign_o,
  output logic             special_o,
  output logic             big_o,
  output logic [SIG_W-1:0] sig_o,
  output logic [SH_W-1:0]  sh_o
);
  localparam logic [EXP_W:0] POINT_POS = (EXP_W+1)'(BIAS + MAN_W);
  localparam logic [EXP_W:0] TINY_LIM  = (EXP_W+1)'(BIAS + MAN_W - SH_MAX);
  localparam logic [EXP_W:0] BIG_LIM   = (EXP_W+1)'(BIAS + INT_W);

  logic [EXP_W-1:0] exp_f;
  logic [EXP_W:0]   e_eff;
  logic             is_norm;

  assign sign_o  = op_i[FP_W-1];
  assign exp_f   = op_i[MAN_W +: EXP_W];
  assign is_norm = |exp_f;
  // subnormals share the scale of exponent 1
  assign e_eff     = is_norm ? {1'b0, exp_f} : (EXP_W+1)'(1);
  assign special_o = &exp_f;
  assign big_o     = !special_o && (e_eff >= BIG_LIM);
  assign sig_o     = {is_norm, op_i[MAN_W-1:0]};

  always_comb begin
    if (big_o || special_o)      sh_o = '0;
    else if (e_eff <= TINY_LIM)  sh_o = SH_W'(SH_MAX);
    else                         sh_o = SH_W'(POINT_POS - e_eff);
  end
endmodule

// File: rtl/f2i_align.sv
`timescale 1ns/1ps
module f2i_align
  import f2i_pkg::*;
(
  input  logic [SIG_W-1:0] sig_i,
  input  logic [SH_W-1:0]  sh_i,
  output logic [MAG_W-1:0] int_o,
  output logic             rnd_o,
  output logic             sticky_o,
  output logic             ovf_o
);
  logic [ALN_W-1:0] wide;

  assign wide     = {sig_i, {SH_MAX{1'b0}}} >> sh_i;
  assign int_o    = wide[SH_MAX +: MAG_W];
  assign rnd_o    = wide[SH_MAX-1];
  assign sticky_o = |wide[SH_MAX-2:0];
  // integer bits beyond the magnitude field mean overflow
  assign ovf_o    = |wide[ALN_W-1:SH_MAX+MAG_W];

  always_comb begin
    if (sh_i == SH_W'(SH_MAX))
      assert_tiny_no_int_R9: assert (int_o == '0 && !rnd_o);
  end
endmodule

// File: rtl/f2i_round.sv
`timescale 1ns/1ps
module f2i_round
  import f2i_pkg::*;
(
  input  logic             sign_i,
  input  logic             special_i,
  input  logic             big_i,
  input  logic             ovf_i,
  input  logic [MAG_W-1:0] int_i,
  input  logic             rnd_i,
  input  logic             sticky_i,
  input  rmode_e           rmode_i,
  output logic [INT_W-1:0] res_o,
  output logic             invalid_o,
  output logic             inexact_o
);
  localparam logic [MAG_W-1:0] LIM = MAG_W'(1) << (INT_W - 1);

  logic             lost;
  logic             inc;
  logic [MAG_W-1:0] mag_r;
  logic             range_bad;

  assign lost = rnd_i | sticky_i;

  always_comb begin
    unique case (rmode_i)
      RM_NEAR: inc = rnd_i & (sticky_i | int_i[0]);
      RM_DOWN: inc = sign_i & lost;
      RM_UP:   inc = ~sign_i & lost;
      default: inc = 1'b0;
    endcase
  end

  assign mag_r     = int_i + MAG_W'(inc);
  // negative side admits exactly 2^(w-1)
  assign range_bad = sign_i ? (mag_r > LIM) : (mag_r >= LIM);
  assign invalid_o = special_i | big_i | ovf_i | range_bad;
  assign inexact_o = lost & ~invalid_o;

  always_comb begin
    if (invalid_o)   res_o = INDEF;
    else if (sign_i) res_o = -mag_r[INT_W-1:0];
    else             res_o = mag_r[INT_W-1:0];
  end

  always_comb begin
    if (!lost)
      assert_exact_no_inc_R2: assert (!inc);
  end
endmodule

// File: rtl/f2i_cvt.sv
`timescale 1ns/1ps
module f2i_cvt
  import f2i_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FP_W-1:0]   op_i,
  input  logic [1:0]        rmode_i,
  output logic [INT_W-1:0]  res_o,
  output logic              invalid_o,
  output logic              inexact_o
);
  logic             sign, special, big, ovf, rnd, sticky;
  logic [SIG_W-1:0] sig;
  logic [SH_W-1:0]  sh;
  logic [MAG_W-1:0] int_part;
  logic [INT_W-1:0] res_d;
  logic             inv_d, inx_d;

  f2i_unpack u_unpack (
    .op_i      (op_i),
    .sign_o    (sign),
    .special_o (special),
    .big_o     (big),
    .sig_o     (sig),
    .sh_o      (sh)
  );

  f2i_align u_align (
    .sig_i    (sig),
    .sh_i     (sh),
    .int_o    (int_part),
    .rnd_o    (rnd),
    .sticky_o (sticky),
    .ovf_o    (ovf)
  );

  f2i_round u_round (
    .sign_i    (sign),
    .special_i (special),
    .big_i     (big),
    .ovf_i     (ovf),
    .int_i     (int_part),
    .rnd_i     (rnd),
    .sticky_i  (sticky),
    .rmode_i   (rmode_e'(rmode_i)),
    .res_o     (res_d),
    .invalid_o (inv_d),
    .inexact_o (inx_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_o     <= '0;
      invalid_o <= 1'b0;
      inexact_o <= 1'b0;
    end else begin
      res_o     <= res_d;
      invalid_o <= inv_d;
      inexact_o <= inx_d;
    end
  end

  assert_indef_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    invalid_o |-> (res_o == INDEF));

  assert_flags_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(invalid_o && inexact_o));

  assert_special_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&op_i[MAN_W +: EXP_W]) |=> invalid_o);

  assert_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i[FP_W-2:0] == '0) |=> (res_o == '0 && !invalid_o && !inexact_o));
endmodule

// File: tb/f2i_cvt_tb.sv
`timescale 1ns/1ps
module f2i_cvt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] op_i = '0;
  logic [1:0]  rmode_i = '0;
  logic [31:0] res_o;
  logic        invalid_o, inexact_o;
  int          n_checks = 0;
  int          n_err = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  f2i_cvt dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .op_i      (op_i),
    .rmode_i   (rmode_i),
    .res_o     (res_o),
    .invalid_o (invalid_o),
    .inexact_o (inexact_o)
  );

  task automatic model(input logic [63:0] x, input logic [1:0] rm,
                       output logic [31:0] er, output logic ei, output logic ex);
    real v, r, f, d;
    int  iv;
    if (x[62:52] == 11'h7ff) begin
      er = 32'h8000_0000; ei = 1'b1; ex = 1'b0;
      return;
    end
    v = $bitstoreal(x);
    case (rm)
      2'd1: r = $floor(v);
      2'd2: r = $ceil(v);
      2'd3: r = (v >= 0.0) ? $floor(v) : $ceil(v);
      default: begin
        f = $floor(v);
        d = v - f;
        if (d > 0.5) r = f + 1.0;
        else if (d < 0.5) r = f;
        else if ((f - 2.0 * $floor(f / 2.0)) != 0.0) r = f + 1.0;
        else r = f;
      end
    endcase
    if (r >= 2147483648.0 || r < -2147483648.0) begin
      er = 32'h8000_0000; ei = 1'b1; ex = 1'b0;
    end else begin
      iv = $rtoi(r);
      er = iv; ei = 1'b0; ex = (r != v);
    end
  endtask

  task automatic check(input logic [63:0] x, input logic [1:0] rm, input string tag);
    logic [31:0] er;
    logic        ei, ex;
    model(x, rm, er, ei, ex);
    op_i = x;
    rmode_i = rm;
    @(negedge clk);
    n_checks++;
    if (res_o !== er || invalid_o !== ei || inexact_o !== ex) begin
      n_err++;
      $display("FAIL %s op=%h rm=%0d res=%h exp=%h inv=%b exp=%b inx=%b exp=%b",
               tag, x, rm, res_o, er, invalid_o, ei, inexact_o, ex);
    end
  endtask

  task automatic all_modes(input logic [63:0] x, input string tag);
    for (int m = 0; m < 4; m++) check(x, 2'(m), tag);
  endtask

  task automatic summary();
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [63:0] x;
    real         rv;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    n_checks++;
    if (res_o !== 32'd0 || invalid_o !== 1'b0 || inexact_o !== 1'b0) begin
      n_err++;
      $display("FAIL R1 reset res=%h exp=0 inv=%b inx=%b exp=0", res_o, invalid_o, inexact_o);
    end
    rst_n = 1'b1;
    @(negedge clk);
    // R1: input applied, output unchanged until next edge
    op_i = 64'h3FF0_0000_0000_0000;
    rmode_i = 2'd0;
    #1;
    n_checks++;
    if (res_o !== 32'd0) begin
      n_err++;
      $display("FAIL R1 early res=%h exp=%h", res_o, 32'd0);
    end
    @(negedge clk);
    n_checks++;
    if (res_o !== 32'd1) begin
      n_err++;
      $display("FAIL R1 latency res=%h exp=%h", res_o, 32'd1);
    end

    all_modes(64'h3FF0_0000_0000_0000, "R2");  // 1.0
    all_modes(64'h41DF_FFFF_FFC0_0000, "R2");  // 2^31-1
    all_modes(64'hC1E0_0000_0000_0000, "R7");  // -2^31
    all_modes(64'h41E0_0000_0000_0000, "R7");  // 2^31
    all_modes(64'h41DF_FFFF_FFE0_0000, "R7");  // 2^31-0.5
    all_modes(64'hC1E0_0000_0010_0000, "R7");  // -2^31-0.5
    all_modes(64'hC1E0_0000_0020_0000, "R7");  // -2^31-1
    all_modes(64'h7E37_E43C_8800_759C, "R7");  // 1e300
    check(64'h4004_0000_0000_0000, 2'd0, "R4");  // 2.5
    check(64'h400C_0000_0000_0000, 2'd0, "R4");  // 3.5
    check(64'hC004_0000_0000_0000, 2'd0, "R4");  // -2.5
    check(64'h3FE0_0000_0000_0000, 2'd0, "R4");  // 0.5
    all_modes(64'hBFFC_0000_0000_0000, "R5");  // -1.75
    all_modes(64'h4004_0000_0000_0000, "R5");
    all_modes(64'h7FF0_0000_0000_0000, "R6");
    all_modes(64'hFFF0_0000_0000_0000, "R6");
    all_modes(64'h7FF8_0000_0000_0000, "R6");
    all_modes(64'h7FF0_0000_0000_0001, "R6");
    all_modes(64'h0000_0000_0000_0000, "R9");
    all_modes(64'h8000_0000_0000_0000, "R9");
    all_modes(64'h0000_0000_0000_0001, "R9");
    all_modes(64'h8000_0000_0000_0001, "R9");
    all_modes(64'h3FDF_FFFF_FFFF_FFFF, "R9");

    for (int i = 0; i < 4000; i++) begin
      int unsigned sel;
      sel = $urandom % 4;
      x = {$urandom, $urandom};
      if (sel == 1 || sel == 2) x[62:52] = 11'(1020 + ($urandom % 38));
      else if (sel == 3) begin
        rv = real'($urandom % 32'h8000_0000) + 0.5;
        if ($urandom % 2) rv = -rv;
        x = $realtobits(rv);
      end
      check(x, 2'($urandom % 4), (sel == 3) ? "R4" : "R8");
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule